// File: doc/BRIEF.md
# SPI Peripheral Byte Shifter

This block is the bit-level engine of a SPI peripheral. An active-low select frames each transfer. The block takes bytes from a transmit source and serialises them onto MISO. It also gathers the bits arriving on MOSI into bytes and hands each one to a receive sink. The host SCK and the select are sampled with the local core clock, and the block acts on the SCK edges it detects. The host therefore has to run SCK at no more than a quarter of the core clock rate.

Clock polarity and clock phase are both programmable. The transmit direction and the receive direction each have their own bit order. Frame ends are defined for partial bytes:
- A partial receive byte is dropped.
- A transmit byte is only marked as consumed once its seventh bit has gone out.
- A byte cut short before that point is sent again in the next frame.

The host may stop SCK at any point with the select held low. SCK toggles and select pulses that carry no data leave no trace. When no transmit byte is waiting at a byte start, the block sends zeros and flags an underflow.

Top module: `spi_dev_shifter`

## Requirements
- R1: The lead edge is the SCK edge that leaves the idle level `cpol`. When `cpha`=0, MOSI is sampled on lead edges and MISO changes after trail edges. When `cpha`=1, MISO changes after lead edges and MOSI is sampled on trail edges. With `cpha`=0, MISO already carries the first bit while `csN` is high.
- R2: `txLsbFirst`=1 sends bit 0 of each transmit byte first, and 0 sends bit 7 first. `rxLsbFirst`=1 puts the first received bit into bit 0 of `rxData`, and 0 puts it into bit 7. The two settings are independent.
- R3: One cycle after the sample edge of the eighth bit of a byte, `rxValid` is high for exactly one cycle. In that cycle `rxData` holds the assembled byte.
- R4: A frame that ends with fewer than eight bits of a byte sampled produces no `rxValid` for that byte. The next frame starts a fresh byte.
- R5: If `csN` rises after fewer than seven bits of a transmit byte, that byte is not popped. The next frame sends it again from its first bit.
- R6: A transmit byte is popped by a one-cycle `txReady` pulse one cycle after its seventh sample edge. A byte popped this way is not sent again, even if `csN` rises before its eighth bit.
- R7: If no transmit byte is valid when a byte starts, that byte goes out as all zeros. `txUnderflow` then pulses for one cycle, one cycle after that byte's first sample edge.
- R8: SCK toggles while `csN` is high change no output, pop nothing and receive nothing. The next frame starts at bit 0.
- R9: A low pulse on `csN` with no SCK edge pops nothing, receives nothing and flags no underflow.
- R10: While `csN` is low and SCK does not move, MISO holds its value. When SCK resumes, shifting continues at the same bit position.
- R11: While `rstN` is low, `miso`, `txReady`, `rxValid` and `txUnderflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to sample SCK |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Idle level of SCK |
| cpha | input | 1 | 0: sample on lead edge; 1: sample on trail edge |
| txLsbFirst | input | 1 | Transmit bit order, 1 = LSB first |
| rxLsbFirst | input | 1 | Receive bit order, 1 = LSB first |
| sck | input | 1 | Host serial clock |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| txData | input | DataW | Transmit byte offered by the source |
| txValid | input | 1 | Source holds a byte |
| txReady | output | 1 | One-cycle pop of the transmit byte |
| rxData | output | DataW | Received byte |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| txUnderflow | output | 1 | One-cycle pulse when a byte starts with no data |

## Verification
Every frame runs full-duplex in all four clock modes, under every pairing of transmit and receive bit order. This separates a swapped sample or shift edge from a wrong bit order in just one direction. Frames cut off at three, five and seven bits show where a byte counts as consumed, and that a partial receive byte is dropped. Some frames include a long SCK pause in the middle of a byte, which separates holding the bit position from restarting the byte. A drained source and a source holding a single byte expose the zero fill and the underflow pulse. Stray SCK toggles and an empty select pulse, each followed by a clean frame, show that they leave no state behind.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  // strobes from control to datapath, valid for one core clock
  typedef struct packed {
    logic idle;       // select inactive
    logic sample;     // capture MOSI
    logic shift;      // update MISO
    logic byteFirst;  // sample of bit 0 of a byte
    logic popPoint;   // sample of the second to last bit
    logic byteEnd;    // sample of the last bit
  } shiftCtrl_t;

endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int DataW = 8,
  localparam int CntW = $clog2(DataW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            sck,
  input  logic            csN,
  output shiftCtrl_t      ctrlStb,
  output logic [CntW-1:0] bitIdx
);

  localparam logic [CntW-1:0] LastIdx = CntW'(DataW - 1);
  localparam logic [CntW-1:0] PopIdx  = CntW'(DataW - 2);

  logic sckPrev;
  logic riseEdge, fallEdge, leadEdge, trailEdge;
  logic sampleEn, shiftEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sck;
  end

  assign riseEdge  = sck & ~sckPrev;
  assign fallEdge  = ~sck & sckPrev;
  assign leadEdge  = cpol ? fallEdge : riseEdge;
  assign trailEdge = cpol ? riseEdge : fallEdge;
  assign sampleEn  = ~csN & (cpha ? trailEdge : leadEdge);
  assign shiftEn   = ~csN & (cpha ? leadEdge : trailEdge);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         bitIdx <= '0;
    else if (csN)      bitIdx <= '0;
    else if (sampleEn) bitIdx <= (bitIdx == LastIdx) ? '0 : bitIdx + 1'b1;
  end

  always_comb begin
    ctrlStb.idle      = csN;
    ctrlStb.sample    = sampleEn;
    ctrlStb.shift     = shiftEn;
    ctrlStb.byteFirst = sampleEn & (bitIdx == '0);
    ctrlStb.popPoint  = sampleEn & (bitIdx == PopIdx);
    ctrlStb.byteEnd   = sampleEn & (bitIdx == LastIdx);
  end

endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_shift_pkg::*;
#(
  parameter int DataW = 8,
  localparam int CntW = $clog2(DataW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftCtrl_t       ctrlStb,
  input  logic [CntW-1:0]  bitIdx,
  input  logic             txLsbFirst,
  input  logic             rxLsbFirst,
  input  logic             mosi,
  output logic             miso,
  input  logic [DataW-1:0] txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [DataW-1:0] rxData,
  output logic             rxValid,
  output logic             txUnderflow
);

  logic [DataW-1:0] txByte, srcByte, rxShift, rxNext;
  logic             txHave;

  function automatic logic pickBit(logic [DataW-1:0] v, logic [CntW-1:0] i, logic lsb);
    logic [CntW-1:0] j;
    j = lsb ? i : CntW'(DataW - 1) - i;
    return v[j];
  endfunction

  assign srcByte = txValid ? txData : '0;
  assign rxNext  = rxLsbFirst ? {mosi, rxShift[DataW-1:1]}
                              : {rxShift[DataW-2:0], mosi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte      <= '0;
      txHave      <= 1'b0;
      miso        <= 1'b0;
      rxShift     <= '0;
      rxData      <= '0;
      rxValid     <= 1'b0;
      txReady     <= 1'b0;
      txUnderflow <= 1'b0;
    end else begin
      txReady     <= ctrlStb.popPoint & txHave;
      txUnderflow <= ctrlStb.byteFirst & ~txHave;
      rxValid     <= ctrlStb.byteEnd;
      if (ctrlStb.byteEnd) rxData <= rxNext;
      if (ctrlStb.idle) begin
        txByte  <= srcByte;
        txHave  <= txValid;
        miso    <= pickBit(srcByte, '0, txLsbFirst);
        rxShift <= '0;
      end else begin
        if (ctrlStb.sample) rxShift <= rxNext;
        if (ctrlStb.byteEnd) begin
          txByte <= srcByte;
          txHave <= txValid;
        end
        if (ctrlStb.shift) miso <= pickBit(txByte, bitIdx, txLsbFirst);
      end
    end
  end

endmodule

// File: rtl/spi_dev_shifter.sv
module spi_dev_shifter
  import spi_shift_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             txLsbFirst,
  input  logic             rxLsbFirst,
  input  logic             sck,
  input  logic             csN,
  input  logic             mosi,
  output logic             miso,
  input  logic [DataW-1:0] txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [DataW-1:0] rxData,
  output logic             rxValid,
  output logic             txUnderflow
);

  localparam int CntW = $clog2(DataW);

  shiftCtrl_t      ctrlStb;
  logic [CntW-1:0] bitIdx;

  spi_shift_ctrl #(.DataW(DataW)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cpol    (cpol),
    .cpha    (cpha),
    .sck     (sck),
    .csN     (csN),
    .ctrlStb (ctrlStb),
    .bitIdx  (bitIdx)
  );

  spi_shift_dp #(.DataW(DataW)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlStb     (ctrlStb),
    .bitIdx      (bitIdx),
    .txLsbFirst  (txLsbFirst),
    .rxLsbFirst  (rxLsbFirst),
    .mosi        (mosi),
    .miso        (miso),
    .txData      (txData),
    .txValid     (txValid),
    .txReady     (txReady),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .txUnderflow (txUnderflow)
  );

endmodule

// File: rtl/spi_dev_shifter_chk.sv
module spi_dev_shifter_chk (
  input logic clk,
  input logic rstN,
  input logic sck,
  input logic csN,
  input logic miso,
  input logic txReady,
  input logic rxValid,
  input logic txUnderflow
);

  // R10: no SCK movement while selected keeps MISO steady
  p_miso_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $stable(sck)) |=> $stable(miso));

  // R3: receive strobe lasts a single cycle
  p_rx_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R8: nothing is received while deselected
  p_no_rx_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !rxValid);

  // R6: pops are single pulses and never come from an idle cycle
  p_pop_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> !txReady);

  p_no_pop_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !txReady);

  // R7: underflow only follows a selected cycle
  p_underflow_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflow |-> $past(!csN));

endmodule

bind spi_dev_shifter spi_dev_shifter_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .sck         (sck),
  .csN         (csN),
  .miso        (miso),
  .txReady     (txReady),
  .rxValid     (rxValid),
  .txUnderflow (txUnderflow)
);

// File: tb/spi_dev_shifter_tb.sv
module spi_dev_shifter_tb_top;

  localparam int ClkPeriod = 10;
  localparam int Half      = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, txLsb = 1'b0, rxLsb = 1'b0;
  logic sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, txReady, rxValid, txUnderflow, txValid;
  logic [7:0] txData, rxData;

  logic [7:0] mem [0:255];
  logic [7:0] rxLog [0:255];
  int srcHead = 0, srcCnt = 0, rxNum = 0, ufNum = 0, expHead = 0;
  int testCnt = 0, failCnt = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  assign txValid = srcHead < srcCnt;
  assign txData  = mem[srcHead[7:0]];

  spi_dev_shifter dut_i (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha),
    .txLsbFirst(txLsb), .rxLsbFirst(rxLsb),
    .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .txUnderflow(txUnderflow)
  );

  // source, sink and underflow monitors, away from the active edge
  always @(negedge clk) begin
    if (txReady && txValid) srcHead <= srcHead + 1;
    if (rxValid) begin
      rxLog[rxNum[7:0]] <= rxData;
      rxNum <= rxNum + 1;
    end
    if (txUnderflow) ufNum <= ufNum + 1;
  end

  function automatic logic bitOf(logic [7:0] b, int i, logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic spiBits(input int nbits, input logic [63:0] mo, input int pauseAt,
                         output logic [63:0] mi);
    mi  = '0;
    csN = 1'b0;
    repeat (Half) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      if (!cpha) begin
        mosi = mo[k];
        repeat (Half) @(negedge clk);
        mi[k] = miso;
        sck = ~cpol;
        repeat (Half) @(negedge clk);
        sck = cpol;
      end else begin
        sck  = ~cpol;
        mosi = mo[k];
        repeat (Half) @(negedge clk);
        mi[k] = miso;
        sck = cpol;
        repeat (Half) @(negedge clk);
      end
      if (k == pauseAt) begin
        logic m0;
        repeat (2) @(negedge clk);
        m0 = miso;
        repeat (40) @(negedge clk);
        chk("R10", "miso during pause", {63'd0, miso}, {63'd0, m0});
      end
    end
    repeat (Half) @(negedge clk);
    csN = 1'b1;
    repeat (2*Half) @(negedge clk);
  endtask

  task automatic runFrame(string req, int nbits, int pauseAt);
    logic [7:0] mb [8];
    logic [63:0] mo, mi, em;
    int startHead, rxB, ufB, full, ufExp, consumed, limit;
    for (int b = 0; b < 8; b++) mb[b] = 8'($urandom);
    startHead = expHead;
    rxB = rxNum;
    ufB = ufNum;
    mo = '0;
    em = '0;
    for (int k = 0; k < nbits; k++) begin
      int idx;
      logic [7:0] src;
      idx = startHead + k/8;
      src = (idx < srcCnt) ? mem[idx] : 8'h00;
      mo[k] = bitOf(mb[k/8], k%8, rxLsb);
      em[k] = bitOf(src, k%8, txLsb);
    end
    ufExp = 0;
    for (int b = 0; b < (nbits+7)/8; b++)
      if (startHead + b >= srcCnt) ufExp++;
    spiBits(nbits, mo, pauseAt, mi);
    chk(req, "miso stream", mi, em);
    full = nbits/8;
    chk(req, "rx byte count", 64'(rxNum - rxB), 64'(full));
    for (int b = 0; b < full; b++)
      chk(req, "rx byte", {56'd0, rxLog[(rxB+b) % 256]}, {56'd0, mb[b]});
    consumed = full + ((nbits % 8 == 7) ? 1 : 0);
    limit = (srcCnt > startHead) ? srcCnt : startHead;
    expHead = (startHead + consumed > limit) ? limit : startHead + consumed;
    chk(req, "source pops", 64'(srcHead), 64'(expHead));
    chk(req, "underflow pulses", 64'(ufNum - ufB), 64'(ufExp));
  endtask

  task automatic setMode(int m, logic tl, logic rl);
    cpol  = m[1];
    cpha  = m[0];
    sck   = m[1];
    txLsb = tl;
    rxLsb = rl;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int hB, rB, uB, save;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    srcCnt = 200;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11", "miso in reset", {63'd0, miso}, 64'd0);
    chk("R11", "txReady in reset", {63'd0, txReady}, 64'd0);
    chk("R11", "rxValid in reset", {63'd0, rxValid}, 64'd0);
    chk("R11", "txUnderflow in reset", {63'd0, txUnderflow}, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R6: all modes, mixed orders
    for (int m = 0; m < 4; m++) begin
      setMode(m, m[0] ^ m[1], ~(m[0] ^ m[1]));
      runFrame("R1 R2 R3 R6", 16, -1);
      setMode(m, m[0], m[1]);
      runFrame("R1 R2 R3 R6", 24, -1);
    end

    // R4 R5: cut short before the seventh bit
    setMode(0, 1'b0, 1'b0);
    runFrame("R4 R5", 5, -1);
    runFrame("R5", 8, -1);
    setMode(3, 1'b1, 1'b0);
    runFrame("R4 R5", 3, -1);
    runFrame("R5", 8, -1);

    // R6: cut after the seventh bit
    setMode(1, 1'b0, 1'b1);
    runFrame("R6", 7, -1);
    runFrame("R6", 8, -1);

    // R8: stray SCK while deselected
    hB = srcHead; rB = rxNum; uB = ufNum;
    for (int t = 0; t < 10; t++) begin
      sck = ~sck;
      repeat (Half) @(negedge clk);
    end
    sck = cpol;
    repeat (Half) @(negedge clk);
    chk("R8", "pops after stray sck", 64'(srcHead), 64'(hB));
    chk("R8", "rx after stray sck", 64'(rxNum), 64'(rB));
    chk("R8", "underflow after stray sck", 64'(ufNum), 64'(uB));
    runFrame("R8", 8, -1);

    // R9: select pulse without SCK
    hB = srcHead; rB = rxNum; uB = ufNum;
    csN = 1'b0;
    repeat (6) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "pops after empty select", 64'(srcHead), 64'(hB));
    chk("R9", "rx after empty select", 64'(rxNum), 64'(rB));
    chk("R9", "underflow after empty select", 64'(ufNum), 64'(uB));
    runFrame("R9", 8, -1);

    // R10: host pause mid-byte
    setMode(0, 1'b1, 1'b1);
    runFrame("R10", 16, 4);
    setMode(3, 1'b0, 1'b0);
    runFrame("R10", 16, 10);

    // R7: drained source, then a single byte
    save = srcCnt;
    srcCnt = srcHead;
    setMode(2, 1'b0, 1'b1);
    runFrame("R7", 16, -1);
    srcCnt = srcHead + 1;
    repeat (2) @(negedge clk);
    runFrame("R7", 16, -1);
    srcCnt = save;
    repeat (2) @(negedge clk);

    // random mix
    for (int it = 0; it < 16; it++) begin
      int nb, pa;
      setMode(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      nb = int'($urandom_range(1, 24));
      pa = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, nb - 1)) : -1;
      runFrame("R1 R2 R3 R4 R5 R6", nb, pa);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule